// File: doc/BRIEF.md
# Parallel Flash Write Sequencer

This block sits on the host side of a byte-wide asynchronous NOR-style flash. A client hands it one high-level request (program one byte, erase one sector, erase the whole array, or fetch the two identification bytes) with a single-cycle start strobe. The sequencer then plays the unlock and command write cycles onto the flash pins and, for program and erase, keeps reading a status byte until the device reports that its internal operation has ended.

End of an operation is found from bit 6 of the status byte, which flips on every read while the flash is busy. When two reads in a row agree on bit 6 and bit 7 carries the expected final value, the operation is over. A stable bit 6 paired with a wrong bit 7 is treated as a read that may have straddled the moment of completion. In that case two more reads are taken, and the result is accepted only if both are good. A poll budget bounds the wait, and every request ends with a one-clock done pulse that carries the error flag and the identification bytes.

Strobe widths (address setup, write pulse, data hold, read length) are counted in clocks and set by parameters.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A program request (op code 0) issues four write cycles, in order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R2: A sector erase (op code 1) issues six write cycles, in order: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the request address with 30h.
- R3: A chip erase (op code 2) issues the same first five write cycles as R2, then a sixth write of 5555h/10h.
- R4: During a write cycle, chip enable stays low, output enable stays high and write enable pulses low. Address and data are stable for at least one clock before write enable falls and for at least one clock after it rises, with chip enable still low.
- R5: During a read cycle, chip enable and output enable are low and write enable is high.
- R6: Status reads happen only after the last write of the command sequence and target the request address.
- R7: A status read completes the operation when its bit 6 equals bit 6 of the previous status read and its bit 7 equals the expected value. The expected value is bit 7 of the data for a program and 1 for either erase.
- R8: A status read with bit 6 unchanged but bit 7 wrong triggers two further reads. Completion is accepted only if both show the expected bit 7 and agree with each other on bit 6. Otherwise polling resumes, with the second extra read as the new previous read.
- R9: An identification request (op code 3) writes 5555h/AAh, 2AAAh/55h and 5555h/90h, reads address 0 and then address 1, and writes F0h to address 0. The done pulse reports {first byte, second byte} on id_bytes[15:8] and id_bytes[7:0].
- R10: If the POLL_LIMIT-th status read does not complete the operation, done pulses with err high. If that same read does complete it, err stays low. In both cases the block returns to idle.
- R11: Requests are taken only while idle is high; a start while busy causes no bus activity. Done lasts one clock, and err is high only with done.
- R12: Out of reset, all three strobes are high, done is low and idle is high. Whenever idle is high, chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken when idle |
| op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 identify |
| req_addr | input | AW (16) | Byte or sector address |
| req_data | input | 8 | Byte to program |
| idle | output | 1 | Ready for a request |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Poll budget exhausted, valid with done |
| id_bytes | output | 16 | Identification bytes, valid with done |
| fl_addr | output | AW (16) | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
Two conditions can land on the same status read: the read that exhausts the poll budget can also be the read that shows completion. The bench scripts a toggling status stream that settles exactly on read number POLL_LIMIT and expects a clean done. A second stream never settles and must end with err set. The bench also places the suspicious-read confirmation right where completion happens, once with both extra reads good and once with them bad. In each case the exact bus-cycle order and the done result are checked.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_CHIP  = 2'd2,
    OP_IDENT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    JM_NORM,
    JM_CONF1,
    JM_CONF2
  } judge_mode_e;

  localparam logic [14:0] UNLK_A = 15'h5555;
  localparam logic [14:0] UNLK_B = 15'h2AAA;
endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  op_e           op,
  input  logic [2:0]    idx,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [2:0]    n_wr
);
  localparam logic [AW-1:0] A_FIRST  = AW'(UNLK_A);
  localparam logic [AW-1:0] A_SECOND = AW'(UNLK_B);

  logic [7:0] third_code;

  always_comb begin
    case (op)
      OP_PROG:  third_code = 8'hA0;
      OP_IDENT: third_code = 8'h90;
      default:  third_code = 8'h80;
    endcase
  end

  always_comb begin
    case (op)
      OP_PROG:  n_wr = 3'd4;
      OP_IDENT: n_wr = 3'd3;
      default:  n_wr = 3'd6;
    endcase
  end

  always_comb begin
    wr_addr = A_FIRST;
    wr_data = 8'hAA;
    case (idx)
      3'd1: begin wr_addr = A_SECOND; wr_data = 8'h55; end
      3'd2: begin wr_addr = A_FIRST;  wr_data = third_code; end
      3'd3: begin
        if (op == OP_PROG) begin
          wr_addr = req_addr;
          wr_data = req_data;
        end
      end
      3'd4: begin wr_addr = A_SECOND; wr_data = 8'h55; end
      3'd5: begin
        if (op == OP_SECT) begin
          wr_addr = req_addr;
          wr_data = 8'h30;
        end else begin
          wr_addr = A_FIRST;
          wr_data = 8'h10;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
  parameter int AW         = 16,
  parameter int SETUP_CLKS = 1,
  parameter int PULSE_CLKS = 2,
  parameter int HOLD_CLKS  = 1,
  parameter int READ_CLKS  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    fl_rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          fin,
  output logic [7:0]    rbyte
);
  localparam int M1   = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
  localparam int M2   = (HOLD_CLKS > READ_CLKS) ? HOLD_CLKS : READ_CLKS;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_READ} bstate_e;

  bstate_e       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fin      <= 1'b0;
      rbyte    <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        B_IDLE: begin
          if (go) begin
            fl_addr  <= addr;
            fl_wdata <= wdata;
            fl_ce_n  <= 1'b0;
            if (rd) begin
              fl_oe_n <= 1'b0;
              cnt     <= CW'(READ_CLKS - 1);
              st      <= B_READ;
            end else begin
              cnt <= CW'(SETUP_CLKS - 1);
              st  <= B_SETUP;
            end
          end
        end
        B_SETUP: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b0;
            cnt     <= CW'(PULSE_CLKS - 1);
            st      <= B_PULSE;
          end else cnt <= cnt - 1'b1;
        end
        B_PULSE: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            cnt     <= CW'(HOLD_CLKS - 1);
            st      <= B_HOLD;
          end else cnt <= cnt - 1'b1;
        end
        B_HOLD: begin
          if (cnt == '0) begin
            fl_ce_n <= 1'b1;
            fin     <= 1'b1;
            st      <= B_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        B_READ: begin
          if (cnt == '0) begin
            rbyte   <= fl_rdata;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            fin     <= 1'b1;
            st      <= B_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sample,
  input  logic [7:0] rbyte,
  input  logic       exp7,
  output logic       complete
);
  judge_mode_e mode;
  logic        have_prev;
  logic        prev6;
  logic        c1ok;
  logic        same6;
  logic        m7;

  assign same6 = have_prev && (rbyte[6] == prev6);
  assign m7    = (rbyte[7] == exp7);

  always_comb begin
    complete = 1'b0;
    if (sample) begin
      case (mode)
        JM_NORM:  complete = same6 && m7;
        JM_CONF2: complete = c1ok && m7 && (rbyte[6] == prev6);
        default:  complete = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mode      <= JM_NORM;
      have_prev <= 1'b0;
      prev6     <= 1'b0;
      c1ok      <= 1'b0;
    end else if (sample) begin
      prev6     <= rbyte[6];
      have_prev <= 1'b1;
      case (mode)
        JM_NORM:  if (same6 && !m7) mode <= JM_CONF1;
        JM_CONF1: begin
          c1ok <= m7;
          mode <= JM_CONF2;
        end
        default:  mode <= JM_NORM;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int SETUP_CLKS = 1,
  parameter int PULSE_CLKS = 2,
  parameter int HOLD_CLKS  = 1,
  parameter int READ_CLKS  = 2,
  parameter int POLL_LIMIT = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          idle,
  output logic          done,
  output logic          err,
  output logic [15:0]   id_bytes,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    T_IDLE, T_WR, T_WR_W, T_POLL, T_POLL_W,
    T_IDRD, T_IDRD_W, T_EXIT, T_EXIT_W, T_FIN
  } tstate_e;

  tstate_e        state;
  op_e            op_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;
  logic [2:0]     stp;
  logic [PCW-1:0] pcnt;
  logic           idsel;
  logic [15:0]    id_q;
  logic           fail_q;

  logic [AW-1:0]  tw_a;
  logic [7:0]     tw_d;
  logic [2:0]     tw_n;
  logic           b_go, b_rd, b_fin;
  logic [AW-1:0]  b_addr;
  logic [7:0]     b_wd, b_rbyte;
  logic           j_clear, j_sample, j_done;

  flash_cmd_table #(.AW(AW)) u_tbl (
    .op(op_q), .idx(stp), .req_addr(addr_q), .req_data(data_q),
    .wr_addr(tw_a), .wr_data(tw_d), .n_wr(tw_n)
  );

  always_comb begin
    b_go   = 1'b0;
    b_rd   = 1'b0;
    b_addr = '0;
    b_wd   = '0;
    case (state)
      T_WR:   begin b_go = 1'b1; b_addr = tw_a; b_wd = tw_d; end
      T_POLL: begin b_go = 1'b1; b_rd = 1'b1; b_addr = addr_q; end
      T_IDRD: begin b_go = 1'b1; b_rd = 1'b1; b_addr = AW'(idsel); end
      T_EXIT: begin b_go = 1'b1; b_wd = 8'hF0; end
      default: ;
    endcase
  end

  flash_bus_cycle #(
    .AW(AW), .SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS),
    .HOLD_CLKS(HOLD_CLKS), .READ_CLKS(READ_CLKS)
  ) u_bus (
    .clk(clk), .rst(rst), .go(b_go), .rd(b_rd), .addr(b_addr), .wdata(b_wd),
    .fl_rdata(fl_rdata), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fin(b_fin), .rbyte(b_rbyte)
  );

  assign j_clear  = (state == T_IDLE) && start;
  assign j_sample = (state == T_POLL_W) && b_fin;

  flash_poll_judge u_judge (
    .clk(clk), .rst(rst), .clear(j_clear), .sample(j_sample),
    .rbyte(b_rbyte), .exp7((op_q == OP_PROG) ? data_q[7] : 1'b1),
    .complete(j_done)
  );

  assign idle = (state == T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= T_IDLE;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      data_q   <= '0;
      stp      <= '0;
      pcnt     <= '0;
      idsel    <= 1'b0;
      id_q     <= '0;
      fail_q   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      id_bytes <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        T_IDLE: begin
          if (start) begin
            op_q   <= op_e'(op);
            addr_q <= req_addr;
            data_q <= req_data;
            stp    <= '0;
            pcnt   <= '0;
            idsel  <= 1'b0;
            id_q   <= '0;
            fail_q <= 1'b0;
            state  <= T_WR;
          end
        end
        T_WR: state <= T_WR_W;
        T_WR_W: begin
          if (b_fin) begin
            if (stp == tw_n - 3'd1)
              state <= (op_q == OP_IDENT) ? T_IDRD : T_POLL;
            else begin
              stp   <= stp + 3'd1;
              state <= T_WR;
            end
          end
        end
        T_POLL: state <= T_POLL_W;
        T_POLL_W: begin
          if (b_fin) begin
            pcnt <= pcnt + 1'b1;
            if (j_done) state <= T_FIN;
            else if (pcnt == PCW'(POLL_LIMIT - 1)) begin
              fail_q <= 1'b1;
              state  <= T_FIN;
            end else state <= T_POLL;
          end
        end
        T_IDRD: state <= T_IDRD_W;
        T_IDRD_W: begin
          if (b_fin) begin
            if (!idsel) begin
              id_q[15:8] <= b_rbyte;
              idsel      <= 1'b1;
              state      <= T_IDRD;
            end else begin
              id_q[7:0] <= b_rbyte;
              state     <= T_EXIT;
            end
          end
        end
        T_EXIT:   state <= T_EXIT_W;
        T_EXIT_W: if (b_fin) state <= T_FIN;
        T_FIN: begin
          done     <= 1'b1;
          err      <= fail_q;
          id_bytes <= id_q;
          state    <= T_IDLE;
        end
        default: state <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          idle,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_wdata,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n
);
  AST_WE_FRAME: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n)); // R4
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R4
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (!fl_ce_n && $stable(fl_addr) && $stable(fl_wdata))); // R4
  AST_RD_FRAME: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (!fl_ce_n && fl_we_n)); // R5
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle |-> fl_ce_n); // R12
endmodule

bind flash_seq_ctrl flash_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .idle(idle), .done(done), .err(err),
  .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/flash_seq_ctrl_test.sv
module flash_seq_ctrl_test;
  localparam int AW = 16;
  localparam int PL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          idle, done, err;
  logic [15:0]   id_bytes;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic [7:0]    fl_rdata = 8'h00;
  logic          fl_ce_n, fl_oe_n, fl_we_n;

  always #2 clk = ~clk;

  flash_seq_ctrl #(.AW(AW), .POLL_LIMIT(PL)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .req_addr(req_addr),
    .req_data(req_data), .idle(idle), .done(done), .err(err),
    .id_bytes(id_bytes), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n)
  );

  int nchk = 0;
  int nfail = 0;
  bit armed = 1'b0;
  bit finished = 1'b0;
  bit prev_done = 1'b0;

  // expected bus events (scoreboard)
  bit            ev_rd[$];
  logic [AW-1:0] ev_a[$];
  logic [7:0]    ev_d[$];
  string         ev_tag[$];
  logic [7:0]    rd_q[$];
  // expected done results
  bit            x_err[$];
  logic [15:0]   x_id[$];
  string         x_tag[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_wr(logic [AW-1:0] a, logic [7:0] d, string tag);
    ev_rd.push_back(1'b0); ev_a.push_back(a); ev_d.push_back(d); ev_tag.push_back(tag);
  endtask

  task automatic push_rd(logic [AW-1:0] a, logic [7:0] v, string tag);
    ev_rd.push_back(1'b1); ev_a.push_back(a); ev_d.push_back(8'h00); ev_tag.push_back(tag);
    rd_q.push_back(v);
  endtask

  task automatic push_done(bit e, logic [15:0] id, string tag);
    x_err.push_back(e); x_id.push_back(id); x_tag.push_back(tag);
  endtask

  task automatic unlock(logic [7:0] third, string tag);
    push_wr(16'h5555, 8'hAA, tag);
    push_wr(16'h2AAA, 8'h55, tag);
    push_wr(16'h5555, third, tag);
  endtask

  task automatic erase_head(string tag);
    unlock(8'h80, tag);
    push_wr(16'h5555, 8'hAA, tag);
    push_wr(16'h2AAA, 8'h55, tag);
  endtask

  task automatic kick(logic [1:0] o, logic [AW-1:0] a, logic [7:0] d);
    while (!idle) @(negedge clk);
    op = o; req_addr = a; req_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(ev_rd.size() == 0, tag, "bus events left", ev_rd.size(), 0);
    chk(idle == 1'b1, tag, "idle after done", idle, 1);
    ev_rd.delete(); ev_a.delete(); ev_d.delete(); ev_tag.delete(); rd_q.delete();
  endtask

  // write monitor: data taken at the rising write strobe
  always @(posedge fl_we_n) begin
    #1;
    if (armed) begin
      if (ev_rd.size() == 0 || ev_rd[0]) begin
        chk(1'b0, "R6", "unexpected write addr", fl_addr, 0);
      end else begin
        chk(fl_addr == ev_a[0], ev_tag[0], "write addr", fl_addr, ev_a[0]);
        chk(fl_wdata == ev_d[0], ev_tag[0], "write data", fl_wdata, ev_d[0]);
        chk(!fl_ce_n && fl_oe_n, "R4", "strobes at write edge", {fl_ce_n, fl_oe_n}, 2'b01);
        void'(ev_rd.pop_front()); void'(ev_a.pop_front());
        void'(ev_d.pop_front()); void'(ev_tag.pop_front());
      end
    end
  end

  // read monitor: supplies the scripted byte
  always @(negedge fl_oe_n) begin
    #1;
    if (armed) begin
      chk(!fl_ce_n && fl_we_n, "R5", "strobes at read", {fl_ce_n, fl_we_n}, 2'b01);
      if (ev_rd.size() == 0 || !ev_rd[0]) begin
        chk(1'b0, "R6", "unexpected read addr", fl_addr, 0);
        fl_rdata = 8'h00;
      end else begin
        chk(fl_addr == ev_a[0], ev_tag[0], "read addr", fl_addr, ev_a[0]);
        fl_rdata = (rd_q.size() != 0) ? rd_q.pop_front() : 8'h00;
        void'(ev_rd.pop_front()); void'(ev_a.pop_front());
        void'(ev_d.pop_front()); void'(ev_tag.pop_front());
      end
    end
  end

  // done monitor
  always @(posedge clk) begin
    #1;
    if (armed) begin
      if (done) begin
        chk(!prev_done, "R11", "done longer than one clock", 1, 0);
        if (x_err.size() == 0) begin
          chk(1'b0, "R11", "unexpected done", 1, 0);
        end else begin
          chk(err == x_err[0], x_tag[0], "err", err, x_err[0]);
          chk(id_bytes == x_id[0], x_tag[0], "id_bytes", id_bytes, x_id[0]);
          void'(x_err.pop_front()); void'(x_id.pop_front()); void'(x_tag.pop_front());
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R12", "strobes after reset",
        {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
    chk(!done && idle, "R12", "done/idle after reset", {done, idle}, 2'b01);
    armed = 1'b1;

    // R1 program, R7 completion, R11 request while busy is ignored
    unlock(8'hA0, "R1");
    push_wr(16'h1234, 8'h3C, "R1");
    push_rd(16'h1234, 8'h80, "R6");
    push_rd(16'h1234, 8'hC0, "R7");
    push_rd(16'h1234, 8'h80, "R7");
    push_rd(16'h1234, 8'h3C, "R7");
    push_done(1'b0, 16'h0000, "R7");
    kick(2'd0, 16'h1234, 8'h3C);
    repeat (6) @(negedge clk);
    chk(idle == 1'b0, "R11", "idle while busy", idle, 0);
    op = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11");

    // R2 sector erase, bit 7 must read 1
    erase_head("R2");
    push_wr(16'h7000, 8'h30, "R2");
    push_rd(16'h7000, 8'h00, "R6");
    push_rd(16'h7000, 8'h40, "R7");
    push_rd(16'h7000, 8'h00, "R7");
    push_rd(16'h7000, 8'hFF, "R7");
    push_rd(16'h7000, 8'hFF, "R7");
    push_done(1'b0, 16'h0000, "R2");
    kick(2'd1, 16'h7000, 8'h00);
    wait_done("R2");

    // R3 chip erase, R8 confirmation accepted
    erase_head("R3");
    push_wr(16'h5555, 8'h10, "R3");
    push_rd(16'h0000, 8'h40, "R6");
    push_rd(16'h0000, 8'h00, "R8");
    push_rd(16'h0000, 8'h00, "R8");
    push_rd(16'h0000, 8'hFF, "R8");
    push_rd(16'h0000, 8'hFF, "R8");
    push_done(1'b0, 16'h0000, "R8");
    kick(2'd2, 16'h0000, 8'h00);
    wait_done("R3");

    // R8 confirmation rejected, polling resumes
    erase_head("R3");
    push_wr(16'h5555, 8'h10, "R3");
    push_rd(16'h0000, 8'h40, "R8");
    push_rd(16'h0000, 8'h00, "R8");
    push_rd(16'h0000, 8'h00, "R8");
    push_rd(16'h0000, 8'h00, "R8");
    push_rd(16'h0000, 8'h00, "R8");
    push_rd(16'h0000, 8'hFF, "R8");
    push_rd(16'h0000, 8'hFF, "R8");
    push_done(1'b0, 16'h0000, "R8");
    kick(2'd2, 16'h0000, 8'h00);
    wait_done("R8");

    // R10 poll budget exhausted
    unlock(8'hA0, "R1");
    push_wr(16'h00F0, 8'h3C, "R1");
    for (int i = 0; i < PL; i++) push_rd(16'h00F0, (i % 2) ? 8'h40 : 8'h00, "R10");
    push_done(1'b1, 16'h0000, "R10");
    kick(2'd0, 16'h00F0, 8'h3C);
    wait_done("R10");

    // R10 completion on the last allowed read
    erase_head("R2");
    push_wr(16'h3000, 8'h30, "R2");
    for (int i = 0; i < PL - 2; i++) push_rd(16'h3000, (i % 2) ? 8'h40 : 8'h00, "R10");
    push_rd(16'h3000, 8'h80, "R10");
    push_rd(16'h3000, 8'h80, "R10");
    push_done(1'b0, 16'h0000, "R10");
    kick(2'd1, 16'h3000, 8'h00);
    wait_done("R10");

    // R9 identification
    unlock(8'h90, "R9");
    push_rd(16'h0000, 8'h5A, "R9");
    push_rd(16'h0001, 8'hC3, "R9");
    push_wr(16'h0000, 8'hF0, "R9");
    push_done(1'b0, 16'h5AC3, "R9");
    kick(2'd3, 16'h4444, 8'h00);
    wait_done("R9");

    repeat (4) @(negedge clk);
    chk(x_err.size() == 0, "R11", "done results missing", x_err.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule